// File: doc/BRIEF.md
# Capture/Compare Timer Channel with PWM

The block is one channel of a timer: a free-running up-counter that `W` bits wide (16 by default) and `N` general registers (4 by default). Each general register is tied to one pin. It can latch the counter when a chosen edge arrives on its input pin. It can also compare against the counter and act on its output pin when the two are equal. A compare-match can also send the counter back to zero, which gives a programmable period. Every capture, every compare-match and every counter wrap can raise a one-cycle interrupt pulse.

An external trigger input, one bit per register, copies the counter into a register that is in capture mode, even when that register's edge selection is off. This lets another block take time stamps through the channel without disturbing its interrupts. In PWM mode the last register sets the period. The other registers set the high time of their pins, counted in clocks from the start of each period.

Software reaches every register through a simple synchronous write port and a combinational read port. The counter is readable and writable at any time. A write always takes priority over whatever the counter would otherwise do in that cycle.

Top module: `ccp_timer`

## Requirements
- R1: After a synchronous active-low reset, every readable location reads 0, all pin outputs are 0 and all interrupt outputs are 0.
- R2: Each clock the counter advances by one and wraps from all-ones to 0. `irq_ovf` is high for exactly the one cycle in which the counter reads 0 after a wrap.
- R3: Address map: 0..N-1 are the general registers (register N-1 is the last one), N is the counter, N+1..2N are the per-register configuration words, and 2N+1 bit 0 enables PWM. A configuration word has select in bits [1:0], compare mode in bit 2 and clear-on-match in bit 3. Every location reads back what was written.
- R4: In capture mode the select field works as follows: 01 captures on a rising edge, 10 on a falling edge, 11 on both. The pin passes through two synchronizing flops. If a pin changes in cycle c, the counter value of cycle c+2 is in the register in cycle c+3, and `irq_evt` for that register is high in cycle c+3 only.
- R5: With select 00 in capture mode, pin edges leave the register unchanged and raise no interrupt.
- R6: In compare mode, when the counter equals the register, the pin output changes on the next clock. The select field chooses the action: 00 leave it, 01 drive 0, 10 drive 1, 11 invert it.
- R7: Each compare-match pulses that register's `irq_evt` bit for exactly one cycle, at the same clock as the pin action.
- R8: With clear-on-match set on a register in compare mode, the counter reads 0 in the cycle after it equals that register, so it counts 0..value repeatedly.
- R9: An `ext_trig` bit held for one cycle stores that cycle's counter value into its register on the next clock, whenever the register is in capture mode, including select 00. It raises no interrupt. In compare mode the trigger has no effect.
- R10: A write to the counter takes effect on the next clock even when a clear-on-match or a wrap would have happened in the same cycle. Such a write produces no overflow pulse.
- R11: In PWM mode the counter runs 0..P, where P is the value of register N-1. Pin N-1 is held low, no `irq_evt` bit rises, and capture and compare settings are ignored.
- R12: In PWM mode each pin k below N-1 is high exactly while the counter is below duty value k. A duty of 0 gives a pin that stays low, and a duty above P gives a pin that stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one location |
| wr_addr | input | AW | Location to write |
| wr_data | input | W | Data to write |
| rd_addr | input | AW | Location to read |
| rd_data | output | W | Contents of `rd_addr`, combinational |
| pin_in | input | N | Capture input pins, asynchronous |
| pin_out | output | N | Compare / PWM output pins, registered |
| ext_trig | input | N | Synchronous forced-capture strobes, one per register |
| irq_ovf | output | 1 | Counter wrap pulse |
| irq_evt | output | N | Capture or compare-match pulse per register |

## Verification
Two of this block's functions can land in one cycle. The first is a software write to the counter together with a clear-on-match, or with the wrap from all-ones. The bench reads the counter through the read port every cycle until it sits on the clear value, and issues a counter write in that same cycle. It does the same at all-ones. It then expects the written value on the next cycle, and no overflow pulse after the wrap case. A second coincidence comes from PWM mode. The period match resets the pins in the same clock as the counter clears. Sweeps over duty values at zero, inside the period and above the period check every output against the counter value it reads back, cycle by cycle.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
// Shared types for the capture/compare timer channel.
// Assumes a configuration word of four bits fits inside the data width.
package ccp_pkg;

    // Meaning of the 2-bit select field while a register captures.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Meaning of the same field while a register compares.
    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } out_act_e;

    // Per-register configuration word, bit 0 is the LSB of sel.
    typedef struct packed {
        logic       clr_on_match;
        logic       is_cmp;
        logic [1:0] sel;
    } slot_cfg_t;

    localparam int CFG_BITS = $bits(slot_cfg_t);

endpackage

// File: rtl/ccp_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus one history flop for an asynchronous pin.
// Produces single-cycle rise/fall strobes two clocks after the pin moves.
// Assumes the pin is low at reset release.
module ccp_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [2:0] sh_q;

    // Shift the pin through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], pin};
    end

    // Compare the synchronized level with its previous value.
    always_comb begin
        rise = sh_q[1] & ~sh_q[2];
        fall = ~sh_q[1] & sh_q[2];
    end
endmodule

// File: rtl/ccp_counter.sv
`timescale 1ns/1ps
// Free-running up-counter with a load port and a synchronous clear.
// Priority: load, then clear, then increment. A wrap pulses ovf for one
// cycle, aligned with the counter reading zero.
module ccp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    // Advance, clear or load the count and flag wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (clear) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                ovf <= &cnt;
            end
        end
    end
endmodule

// File: rtl/ccp_slot.sv
`timescale 1ns/1ps
// One general register with its pin logic: capture, compare and PWM.
// IS_PERIOD marks the register that sets the period in PWM mode. Its pin
// is held low there. The other registers act as duty registers.
// Assumes the period_hit input is only high while PWM mode is on.
module ccp_slot
    import ccp_pkg::*;
#(
    parameter int W         = 16,
    parameter bit IS_PERIOD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  slot_cfg_t    cfg,
    input  logic         pwm_en,
    input  logic         period_hit,
    input  logic         pin_in,
    input  logic         ext_trig,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] gr,
    output logic         pin_out,
    output logic         clr_req,
    output logic         irq
);
    localparam logic [W-1:0] ONE = W'(1);

    logic rise, fall;
    logic cap_mode, edge_hit, pin_cap, cmp_hit, duty_hit;

    ccp_edge_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .rise (rise),
        .fall (fall)
    );

    // Decode the events this register reacts to in the current cycle.
    always_comb begin
        cap_mode = !pwm_en && !cfg.is_cmp;
        case (edge_sel_e'(cfg.sel))
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
        pin_cap  = cap_mode && edge_hit;
        cmp_hit  = !pwm_en && cfg.is_cmp && (cnt == gr);
        duty_hit = pwm_en && (gr != '0) && (cnt == gr - ONE);
        clr_req  = (cmp_hit && cfg.clr_on_match) ||
                   (IS_PERIOD && pwm_en && (cnt == gr));
    end

    // Register contents: a software write beats any capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                              gr <= '0;
        else if (wr_en)                          gr <= wr_data;
        else if (cap_mode && (edge_hit || ext_trig)) gr <= cnt;
    end

    // Pin output: a PWM waveform or a compare action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
        end else if (pwm_en) begin
            if (IS_PERIOD)       pin_out <= 1'b0;
            else if (period_hit) pin_out <= (gr != '0);
            else if (duty_hit)   pin_out <= 1'b0;
        end else if (cmp_hit) begin
            case (out_act_e'(cfg.sel))
                ACT_LOW:    pin_out <= 1'b0;
                ACT_HIGH:   pin_out <= 1'b1;
                ACT_TOGGLE: pin_out <= ~pin_out;
                default:    pin_out <= pin_out;
            endcase
        end
    end

    // Event interrupt: pin captures and compare-matches only.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= pin_cap || cmp_hit;
    end
endmodule

// File: rtl/ccp_timer.sv
`timescale 1ns/1ps
// Capture/compare timer channel: one counter, N general registers, PWM.
// Address map: 0..N-1 registers, N counter, N+1..2N configurations,
// 2N+1 mode (bit 0 = PWM). Reads are combinational, writes synchronous.
// Assumes N >= 2 and W >= 4.
module ccp_timer
    import ccp_pkg::*;
#(
    parameter  int W  = 16,
    parameter  int N  = 4,
    localparam int AW = $clog2(2 * N + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    input  logic [N-1:0]  ext_trig,
    output logic          irq_ovf,
    output logic [N-1:0]  irq_evt
);
    localparam int A_CNT  = N;
    localparam int A_CFG  = N + 1;
    localparam int A_MODE = 2 * N + 1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] gr_q [N];
    slot_cfg_t    cfg_q [N];
    logic         pwm_q;
    logic [N-1:0] clr_vec;
    logic [N-1:0] gr_wr;
    logic         clr_any, cnt_wr, period_hit;

    // Decode write strobes and counter-level events.
    always_comb begin
        cnt_wr = wr_en && (wr_addr == AW'(A_CNT));
        for (int i = 0; i < N; i++) gr_wr[i] = wr_en && (wr_addr == AW'(i));
        clr_any    = |clr_vec;
        period_hit = pwm_q && (cnt_q == gr_q[N-1]);
    end

    ccp_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_wr),
        .load_val(wr_data),
        .clear   (clr_any),
        .cnt     (cnt_q),
        .ovf     (irq_ovf)
    );

    // Configuration and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
            for (int i = 0; i < N; i++) cfg_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_MODE)) pwm_q <= wr_data[0];
            for (int i = 0; i < N; i++)
                if (wr_addr == AW'(A_CFG + i))
                    cfg_q[i] <= slot_cfg_t'(wr_data[CFG_BITS-1:0]);
        end
    end

    // Read multiplexer over all locations.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CNT))  rd_data = cnt_q;
        if (rd_addr == AW'(A_MODE)) rd_data = {{(W-1){1'b0}}, pwm_q};
        for (int i = 0; i < N; i++) begin
            if (rd_addr == AW'(i))         rd_data = gr_q[i];
            if (rd_addr == AW'(A_CFG + i)) rd_data = {{(W-CFG_BITS){1'b0}}, cfg_q[i]};
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        ccp_slot #(.W(W), .IS_PERIOD(g == N - 1)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt_q),
            .cfg       (cfg_q[g]),
            .pwm_en    (pwm_q),
            .period_hit(period_hit),
            .pin_in    (pin_in[g]),
            .ext_trig  (ext_trig[g]),
            .wr_en     (gr_wr[g]),
            .wr_data   (wr_data),
            .gr        (gr_q[g]),
            .pin_out   (pin_out[g]),
            .clr_req   (clr_vec[g]),
            .irq       (irq_evt[g])
        );
    end
endmodule

// File: rtl/ccp_timer_chk.sv
`timescale 1ns/1ps
// Temporal checks on the timer channel, attached by bind.
module ccp_timer_chk #(
    parameter int W = 16,
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         cnt_wr,
    input logic [W-1:0] wr_data,
    input logic         clr_any,
    input logic         pwm_en,
    input logic [W-1:0] gr_last,
    input logic [N-1:0] pin_out,
    input logic         irq_ovf,
    input logic [N-1:0] irq_evt
);
    // R10: a counter write lands on the next clock whatever else happens.
    p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wr_data)));

    // R2: an uninterrupted increment from all-ones wraps and flags it.
    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !cnt_wr && !clr_any) |=> (irq_ovf && cnt == '0));

    // R2: the overflow pulse only ever coincides with a zero count.
    p_ovf_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> (cnt == '0));

    // R11: the period register sends the counter back to zero.
    p_period_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && cnt == gr_last && !cnt_wr) |=> (cnt == '0));

    // R11: the period register's own pin is held low in PWM mode.
    p_period_pin_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |=> !pin_out[N-1]);

    // R11: no event interrupt arises from a PWM cycle.
    p_no_evt_in_pwm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |=> (irq_evt == '0));
endmodule

bind ccp_timer ccp_timer_chk #(.W(W), .N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt_q),
    .cnt_wr (cnt_wr),
    .wr_data(wr_data),
    .clr_any(clr_any),
    .pwm_en (pwm_q),
    .gr_last(gr_q[N-1]),
    .pin_out(pin_out),
    .irq_ovf(irq_ovf),
    .irq_evt(irq_evt)
);

// File: tb/sim_ccp_timer.sv
`timescale 1ns/1ps
module sim_ccp_timer;
    localparam int W = 16;
    localparam int N = 4;
    localparam int AW = 4;
    localparam int A_CNT = N;
    localparam int A_CFG = N + 1;
    localparam int A_MODE = 2 * N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  ext_trig = '0;
    logic          irq_ovf;
    logic [N-1:0]  irq_evt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic [W-1:0] exp_gr [N];
    logic [N-1:0] exp_pin;

    always #2 clk = ~clk;

    ccp_timer #(.W(W), .N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .ext_trig(ext_trig),
        .irq_ovf(irq_ovf), .irq_evt(irq_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        rd_addr = AW'(a);
        #0.2;
        d = rd_data;
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic [W-1:0] cfgw(input bit clr, input bit cmp, input logic [1:0] sel);
        return {{(W-4){1'b0}}, clr, cmp, sel};
    endfunction

    task automatic wait_cnt(input logic [W-1:0] v, input string tag);
        logic [W-1:0] c;
        for (int k = 0; k < 100; k++) begin
            rd(A_CNT, c);
            if (c == v) return;
            tick();
        end
        chk(tag, 32'(c), 32'(v));
    endtask

    initial begin
        logic [W-1:0] v, c0;
        logic [1:0] acts [8] = '{2'd2, 2'd3, 2'd3, 2'd0, 2'd1, 2'd3, 2'd1, 2'd0};
        repeat (4) tick();
        // R1: reset state of every location and output
        for (int a = 0; a <= A_MODE; a++) begin
            rd(a, v);
            chk($sformatf("R1 loc %0d", a), 32'(v), 0);
        end
        chk("R1 pins/irqs", {pin_out, irq_evt, 7'b0, irq_ovf}, 0);
        rst_n = 1'b1;
        tick();

        // R3: write and read back registers and configuration words
        for (int i = 0; i < N; i++) begin
            wr(i, 16'h5A3C ^ W'(i * 16'h1111));
            wr(A_CFG + i, W'(i + 9));
            rd(i, v);
            chk($sformatf("R3 gr%0d", i), 32'(v), 32'(16'h5A3C ^ W'(i * 16'h1111)));
            rd(A_CFG + i, v);
            chk($sformatf("R3 cfg%0d", i), 32'(v), 32'(i + 9));
        end
        for (int i = 0; i < N; i++) begin
            wr(A_CFG + i, 0);
            wr(i, 0);
            exp_gr[i] = '0;
        end

        // R2: wrap and overflow pulse
        wr(A_CNT, 16'hFFFD);
        for (int k = 0; k < 5; k++) begin
            rd(A_CNT, v);
            chk($sformatf("R2 count step %0d", k), 32'(v), 32'(W'(16'hFFFD + k)));
            chk($sformatf("R2 ovf step %0d", k), 32'(irq_ovf), 32'(k == 3));
            tick();
        end

        // R4/R5/R7: edge-select sweep on every register
        wr(A_CNT, 0);
        for (int i = 0; i < N; i++) begin
            for (int sel = 0; sel < 4; sel++) begin
                wr(A_CFG + i, cfgw(0, 0, 2'(sel)));
                for (int e = 0; e < 2; e++) begin
                    bit hit;
                    hit = (sel == 3) || (sel == 1 && e == 0) || (sel == 2 && e == 1);
                    rd(A_CNT, c0);
                    pin_in[i] = (e == 0);
                    tick(); tick(); tick();
                    if (hit) exp_gr[i] = c0 + 2;
                    rd(i, v);
                    chk($sformatf("R4/R5 gr%0d sel%0d edge%0d", i, sel, e), 32'(v), 32'(exp_gr[i]));
                    chk($sformatf("R7 irq gr%0d sel%0d edge%0d", i, sel, e),
                        32'(irq_evt), hit ? 32'(1 << i) : 0);
                    tick();
                    chk($sformatf("R7 irq single gr%0d", i), 32'(irq_evt), 0);
                    tick();
                end
            end
            wr(A_CFG + i, 0);
        end

        // R9: forced capture with select off, ignored in compare mode
        for (int i = 0; i < N; i++) begin
            rd(A_CNT, c0);
            ext_trig[i] = 1'b1;
            tick();
            ext_trig[i] = 1'b0;
            rd(i, v);
            chk($sformatf("R9 forced gr%0d", i), 32'(v), 32'(c0));
            chk($sformatf("R9 no irq gr%0d", i), 32'(irq_evt), 0);
            wr(A_CFG + i, cfgw(0, 1, 2'd0));
            ext_trig[i] = 1'b1;
            tick();
            ext_trig[i] = 1'b0;
            rd(i, v);
            chk($sformatf("R9 compare ignores gr%0d", i), 32'(v), 32'(c0));
            wr(A_CFG + i, 0);
        end

        // R6/R7: compare action sweep
        exp_pin = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < 8; j++) begin
                wr(A_CFG + i, cfgw(0, 1, acts[j]));
                wr(i, 20);
                wr(A_CNT, 0);
                wait_cnt(20, "R6 match wait");
                tick();
                case (acts[j])
                    2'd1: exp_pin[i] = 1'b0;
                    2'd2: exp_pin[i] = 1'b1;
                    2'd3: exp_pin[i] = ~exp_pin[i];
                    default: ;
                endcase
                chk($sformatf("R6 pins reg%0d act%0d", i, acts[j]), 32'(pin_out), 32'(exp_pin));
                chk($sformatf("R7 cmp irq reg%0d", i), 32'(irq_evt), 32'(1 << i));
                tick();
                chk($sformatf("R7 cmp irq single reg%0d", i), 32'(irq_evt), 0);
            end
            wr(A_CFG + i, 0);
        end

        // R8: clear on match, last register then first register
        wr(A_CFG + N - 1, cfgw(1, 1, 2'd0));
        wr(N - 1, 9);
        wr(A_CNT, 0);
        for (int k = 0; k < 30; k++) begin
            rd(A_CNT, v);
            chk($sformatf("R8 period10 step %0d", k), 32'(v), 32'(k % 10));
            tick();
        end
        wr(A_CFG + N - 1, 0);
        wr(A_CFG, cfgw(1, 1, 2'd0));
        wr(0, 4);
        wr(A_CNT, 0);
        for (int k = 0; k < 15; k++) begin
            rd(A_CNT, v);
            chk($sformatf("R8 period5 step %0d", k), 32'(v), 32'(k % 5));
            tick();
        end

        // R10: counter write against clear and against wrap
        wait_cnt(4, "R10 clear wait");
        wr(A_CNT, 500);
        rd(A_CNT, v);
        chk("R10 write beats clear", 32'(v), 500);
        tick();
        rd(A_CNT, v);
        chk("R10 count after write", 32'(v), 501);
        wr(A_CFG, 0);
        wr(A_CNT, 16'hFFFF);
        wr(A_CNT, 7);
        rd(A_CNT, v);
        chk("R10 write beats wrap", 32'(v), 7);
        chk("R10 no ovf on write", 32'(irq_ovf), 0);

        // R11/R12: PWM duty sweep with period 7, compare settings ignored
        for (int i = 0; i < N; i++) wr(A_CFG + i, cfgw(1, 1, 2'd3));
        wr(N - 1, 7);
        wr(A_MODE, 1);
        for (int t = 0; t < 10; t++) begin
            int d0, d1, d2;
            d0 = t; d1 = (t + 3) % 10; d2 = 9 - t;
            wr(0, W'(d0)); wr(1, W'(d1)); wr(2, W'(d2));
            wr(A_CNT, 0);
            repeat (9) tick();
            for (int k = 0; k < 16; k++) begin
                logic [N-1:0] ep;
                rd(A_CNT, v);
                chk($sformatf("R11 count t%0d k%0d", t, k), 32'(v), 32'((1 + k) % 8));
                ep = {1'b0, (32'(v) < d2), (32'(v) < d1), (32'(v) < d0)};
                chk($sformatf("R12 pins t%0d k%0d", t, k), 32'(pin_out), 32'(ep));
                chk($sformatf("R11 no irq t%0d k%0d", t, k), 32'(irq_evt), 0);
                tick();
            end
        end
        wr(A_MODE, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule